// File: doc/BRIEF.md
# Serial Channel Status and Interrupt-Cause Register

This block holds the status word of one serial channel. It watches four asynchronous modem input lines: carrier, data set ready, clear to send and ring. Each line passes through a synchroniser. The block shows the synchronised level of each line in the status word. A change on either edge of a line sets a sticky per-line change flag.

Two more sticky causes come from neighbouring logic as one-cycle event pulses:
- a receive-data cause, from the receive FIFO;
- a transmit-empty cause, from the transmit FIFO.

An overrun level from the receive FIFO is passed through for reading only.

The host reads the 32-bit word and writes it back. A 1 written to a cause bit clears that cause. All other bits ignore writes, so writing back the word just read clears exactly the causes that were seen. The block combines the latched causes with three enable bits of the channel control word into a single interrupt request.

Top module: `chan_stat_reg`

## Requirements
- R1: While reset is held and right after it ends, with all modem lines low, the status word reads 0x00000000 and `irqReq` is 0.
- R2: Line index 0 (carrier), 1 (data set ready), 2 (clear to send) and 3 (ring) show their levels at status bits 3, 4, 5 and 6.
  - A level change on `modemIn` appears in the status word after exactly SYNC_STAGES rising clock edges (2 by default).
- R3: Change flags sit at status bit 18 (carrier), 16 (data set ready), 17 (clear to send) and 22 (ring).
  - A flag sets on a rising or a falling level of its line, one edge after the new level is shown.
  - It stays set until cleared.
- R4: A one-cycle `rxEvent` pulse sets the receive cause at status bit 0.
  - A one-cycle `txEmptyEvent` pulse sets the transmit-empty cause at bit 25.
  - Both are visible after the next rising edge and stay set until cleared.
- R5: Status bit 13 follows the `overrunIn` level, and a write of 1 to bit 13 has no effect on it.
- R6: A write (`wrEn` high for one cycle) with a 1 in a cause bit (0, 16, 17, 18, 22 or 25) clears that cause at the next edge.
  - Cause bits written as 0 keep their value.
  - Live-level bits (3 to 6, 13) are not affected by any write.
- R7: When a clearing write and a new edge or event for the same cause occur in the same cycle, the cause stays set.
- R8: `irqReq` = (any change flag AND `ctrlWord[0]`) OR (receive cause AND `ctrlWord[2]`) OR (transmit-empty cause AND `ctrlWord[19]`).
  - It follows the latched causes and the control word with no extra cycle.
- R9: A line that is already high when reset ends produces no change flag; its level is still shown.
- R10: Writing back the whole word just read clears every cause shown in it in one write, and leaves the live levels in place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| modemIn | input | 4 | Asynchronous modem lines: [0] carrier, [1] data set ready, [2] clear to send, [3] ring |
| overrunIn | input | 1 | Receive overrun level from the receive FIFO |
| rxEvent | input | 1 | One-cycle pulse: receive data condition |
| txEmptyEvent | input | 1 | One-cycle pulse: transmit FIFO empty condition |
| ctrlWord | input | 32 | Channel control word; bits 0, 2, 19 are the interrupt enables |
| wrEn | input | 1 | Host write strobe for the status word |
| wrData | input | 32 | Host write data; 1 in a cause bit clears it |
| statusWord | output | 32 | Status word as read by the host |
| irqReq | output | 1 | Channel interrupt request |

## Verification
The bench builds the block with the default SYNC_STAGES of 2. With that value, the exact latencies can be checked cycle by cycle:
- two edges from a modem line change to its live bit;
- three edges to its change flag;
- the three-edge arming window after reset.

That cycle accuracy also lets the bench place a clearing write on the very edge where a second line edge is detected, which is the set-wins case.

// File: rtl/chan_stat_pkg.sv
package chan_stat_pkg;

  localparam int STAT_W  = 32;
  localparam int CTRL_W  = 32;
  localparam int MODEM_N = 4;

  // status word positions
  localparam int RX_CAUSE_BIT = 0;
  localparam int LIVE_BASE    = 3;
  localparam int OVR_BIT      = 13;
  localparam int TX_CAUSE_BIT = 25;

  // control word enable positions
  localparam int EN_MODEM_BIT = 0;
  localparam int EN_RX_BIT    = 2;
  localparam int EN_TX_BIT    = 19;

  // change flag position of modem line idx (0 carrier, 1 dsr, 2 cts, 3 ring)
  function automatic int chgBit(input int idx);
    case (idx)
      0:       return 18;
      1:       return 16;
      2:       return 17;
      default: return 22;
    endcase
  endfunction

  // strobes from control to datapath
  typedef struct packed {
    logic [MODEM_N-1:0] clrChg;
    logic               clrRx;
    logic               clrTx;
    logic               armLoad;
  } strobeT;

endpackage

// File: rtl/chan_stat_ctrl.sv
module chan_stat_ctrl
  import chan_stat_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic [STAT_W-1:0]  wrData,
  input  logic [CTRL_W-1:0]  ctrlWord,
  input  logic [MODEM_N-1:0] chgFlags,
  input  logic               rxCause,
  input  logic               txCause,
  output strobeT             strobe,
  output logic               irqReq
);

  localparam int ARM_CYC = SYNC_STAGES + 1;
  localparam int ARM_W   = $clog2(ARM_CYC + 1);

  logic [ARM_W-1:0] armCnt;
  logic             unusedBits;

  // arming window: edge detection stays off until the synchroniser holds real samples
  always_ff @(posedge clk) begin
    if (!rstN) begin
      armCnt <= '0;
    end else if (armCnt != ARM_W'(ARM_CYC)) begin
      armCnt <= armCnt + ARM_W'(1);
    end
  end

  always_comb begin
    strobe.armLoad = (armCnt != ARM_W'(ARM_CYC));
    strobe.clrRx   = wrEn & wrData[RX_CAUSE_BIT];
    strobe.clrTx   = wrEn & wrData[TX_CAUSE_BIT];
    for (int i = 0; i < MODEM_N; i++) begin
      strobe.clrChg[i] = wrEn & wrData[chgBit(i)];
    end
  end

  always_comb begin
    irqReq = ((|chgFlags) & ctrlWord[EN_MODEM_BIT])
           | (rxCause & ctrlWord[EN_RX_BIT])
           | (txCause & ctrlWord[EN_TX_BIT]);
  end

  assign unusedBits = ^{wrData, ctrlWord};

  AST_ARM_STAYS_OFF: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.armLoad |=> !strobe.armLoad); // R9

  AST_IRQ_NEEDS_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    irqReq |-> ((|chgFlags) || rxCause || txCause)); // R8

endmodule

// File: rtl/chan_stat_dpath.sv
module chan_stat_dpath
  import chan_stat_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [MODEM_N-1:0] modemIn,
  input  logic               overrunIn,
  input  logic               rxEvent,
  input  logic               txEmptyEvent,
  input  strobeT             strobe,
  output logic [MODEM_N-1:0] chgFlags,
  output logic               rxCause,
  output logic               txCause,
  output logic [STAT_W-1:0]  statusWord
);

  logic [SYNC_STAGES-1:0][MODEM_N-1:0] syncQ;
  logic [MODEM_N-1:0] lineNow;
  logic [MODEM_N-1:0] linePrev;
  logic [MODEM_N-1:0] edgeHit;

  // synchroniser: the stage count picks the shift form
  generate
    if (SYNC_STAGES == 1) begin : g_sync_one
      always_ff @(posedge clk) begin
        if (!rstN) syncQ <= '0;
        else       syncQ <= modemIn;
      end
    end else begin : g_sync_chain
      always_ff @(posedge clk) begin
        if (!rstN) syncQ <= '0;
        else       syncQ <= {syncQ[SYNC_STAGES-2:0], modemIn};
      end
    end
  endgenerate

  assign lineNow = syncQ[SYNC_STAGES-1];
  assign edgeHit = (lineNow ^ linePrev) & {MODEM_N{~strobe.armLoad}};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      linePrev <= '0;
      chgFlags <= '0;
      rxCause  <= 1'b0;
      txCause  <= 1'b0;
    end else begin
      linePrev <= lineNow;
      chgFlags <= (chgFlags & ~strobe.clrChg) | edgeHit;
      rxCause  <= (rxCause & ~strobe.clrRx) | rxEvent;
      txCause  <= (txCause & ~strobe.clrTx) | txEmptyEvent;
    end
  end

  always_comb begin
    statusWord               = '0;
    statusWord[RX_CAUSE_BIT] = rxCause;
    statusWord[TX_CAUSE_BIT] = txCause;
    statusWord[OVR_BIT]      = overrunIn;
    for (int i = 0; i < MODEM_N; i++) begin
      statusWord[LIVE_BASE + i] = lineNow[i];
      statusWord[chgBit(i)]     = chgFlags[i];
    end
  end

  generate
    for (genvar g = 0; g < MODEM_N; g++) begin : g_chk
      AST_CHG_SETS: assert property (@(posedge clk) disable iff (!rstN)
        edgeHit[g] |=> chgFlags[g]); // R3
      AST_CHG_STICKY: assert property (@(posedge clk) disable iff (!rstN)
        (chgFlags[g] && !strobe.clrChg[g]) |=> chgFlags[g]); // R3
      AST_CHG_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
        (strobe.clrChg[g] && !edgeHit[g]) |=> !chgFlags[g]); // R6
      AST_NO_ARM_FLAG: assert property (@(posedge clk) disable iff (!rstN)
        strobe.armLoad |=> !$rose(chgFlags[g])); // R9
    end
  endgenerate

  AST_RX_SET_WINS: assert property (@(posedge clk) disable iff (!rstN)
    rxEvent |=> rxCause); // R7
  AST_TX_SET_WINS: assert property (@(posedge clk) disable iff (!rstN)
    txEmptyEvent |=> txCause); // R4

endmodule

// File: rtl/chan_stat_reg.sv
module chan_stat_reg
  import chan_stat_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [3:0]  modemIn,
  input  logic        overrunIn,
  input  logic        rxEvent,
  input  logic        txEmptyEvent,
  input  logic [31:0] ctrlWord,
  input  logic        wrEn,
  input  logic [31:0] wrData,
  output logic [31:0] statusWord,
  output logic        irqReq
);

  strobeT             strobe;
  logic [MODEM_N-1:0] chgFlags;
  logic               rxCause;
  logic               txCause;

  chan_stat_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .wrEn     (wrEn),
    .wrData   (wrData),
    .ctrlWord (ctrlWord),
    .chgFlags (chgFlags),
    .rxCause  (rxCause),
    .txCause  (txCause),
    .strobe   (strobe),
    .irqReq   (irqReq)
  );

  chan_stat_dpath #(.SYNC_STAGES(SYNC_STAGES)) u_dpath (
    .clk          (clk),
    .rstN         (rstN),
    .modemIn      (modemIn),
    .overrunIn    (overrunIn),
    .rxEvent      (rxEvent),
    .txEmptyEvent (txEmptyEvent),
    .strobe       (strobe),
    .chgFlags     (chgFlags),
    .rxCause      (rxCause),
    .txCause      (txCause),
    .statusWord   (statusWord)
  );

endmodule

// File: tb/chan_stat_reg_test.sv
module chan_stat_reg_test;

  localparam int CLK_PERIOD = 10;
  localparam int NV = 12;

  // vector: {modem[3:0], ovr, rx, tx, wr, wrData[31:0], ctrl[31:0]}
  localparam logic [71:0] VEC [NV] = '{
    {4'b0001, 4'b0000, 32'h0000_0000, 32'h0000_0000},
    {4'b0001, 4'b0000, 32'h0000_0000, 32'h0000_0001},
    {4'b0001, 4'b0001, 32'h0004_0000, 32'h0000_0001},
    {4'b0110, 4'b0000, 32'h0000_0000, 32'h0000_0000},
    {4'b0110, 4'b0001, 32'h0000_0078, 32'h0000_0000},
    {4'b1110, 4'b0100, 32'h0000_0000, 32'h0000_0004},
    {4'b1110, 4'b0001, 32'h0000_0001, 32'h0000_0004},
    {4'b1110, 4'b0010, 32'h0000_0000, 32'h0008_0000},
    {4'b1110, 4'b1001, 32'h0000_2000, 32'h0000_0000},
    {4'b1110, 4'b0001, 32'h0247_0001, 32'h0008_0005},
    {4'b0000, 4'b0000, 32'h0000_0000, 32'h0008_0005},
    {4'b0000, 4'b0001, 32'h00FF_FFFF, 32'h0008_0005}
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  modemIn = '0;
  logic        overrunIn = 1'b0;
  logic        rxEvent = 1'b0;
  logic        txEmptyEvent = 1'b0;
  logic [31:0] ctrlWord = '0;
  logic        wrEn = 1'b0;
  logic [31:0] wrData = '0;
  logic [31:0] statusWord;
  logic        irqReq;

  int nVec = 0;
  int nBad = 0;
  bit done = 1'b0;

  // model state
  logic [3:0] mLive = '0;
  logic [3:0] mChg = '0;
  logic       mRx = 1'b0;
  logic       mTx = 1'b0;

  chan_stat_reg uut (
    .clk(clk), .rstN(rstN), .modemIn(modemIn), .overrunIn(overrunIn),
    .rxEvent(rxEvent), .txEmptyEvent(txEmptyEvent), .ctrlWord(ctrlWord),
    .wrEn(wrEn), .wrData(wrData), .statusWord(statusWord), .irqReq(irqReq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int flagPos(input int i);
    if (i == 0) return 18;
    if (i == 1) return 16;
    if (i == 2) return 17;
    return 22;
  endfunction

  function automatic logic [31:0] mkWord(input logic [3:0] live, input logic [3:0] chg,
                                         input logic rx, input logic tx, input logic ovr);
    logic [31:0] w;
    w = '0;
    w[0] = rx;
    w[25] = tx;
    w[13] = ovr;
    for (int i = 0; i < 4; i++) begin
      w[3 + i] = live[i];
      w[flagPos(i)] = chg[i];
    end
    return w;
  endfunction

  function automatic logic mkIrq(input logic [3:0] chg, input logic rx, input logic tx,
                                 input logic [31:0] ctl);
    return ((|chg) & ctl[0]) | (rx & ctl[2]) | (tx & ctl[19]);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nVec++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nBad++;
      $display("FAIL watchdog: actual 0x%08h expected 0x%08h", 0, 1);
      $display("  == %0d vectors applied, %0d miscompares ==", nVec, nBad);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    repeat (3) @(negedge clk);
    check("R1 word in reset", statusWord, 32'h0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 word after reset", statusWord, 32'h0);
    check("R1 irq after reset", {31'b0, irqReq}, 32'h0);
    repeat (4) @(negedge clk);

    // table walk: R2 R3 R4 R5 R6 R8
    for (int v = 0; v < NV; v++) begin
      logic [3:0] mdm;
      logic [31:0] dat;
      logic [31:0] ctl;
      logic ovr, rx, tx, wr;
      {mdm, ovr, rx, tx, wr, dat, ctl} = VEC[v];
      modemIn = mdm; overrunIn = ovr; rxEvent = rx; txEmptyEvent = tx;
      wrEn = wr; wrData = dat; ctrlWord = ctl;
      mRx = (mRx & ~(wr & dat[0])) | rx;
      mTx = (mTx & ~(wr & dat[25])) | tx;
      for (int i = 0; i < 4; i++) begin
        mChg[i] = (mChg[i] & ~(wr & dat[flagPos(i)])) | (mdm[i] ^ mLive[i]);
      end
      mLive = mdm;
      @(negedge clk);
      rxEvent = 1'b0; txEmptyEvent = 1'b0; wrEn = 1'b0; wrData = '0;
      @(negedge clk);
      @(negedge clk);
      check($sformatf("R2/R3/R4/R5/R6 word vec %0d", v), statusWord,
            mkWord(mLive, mChg, mRx, mTx, ovr));
      check($sformatf("R8 irq vec %0d", v), {31'b0, irqReq},
            {31'b0, mkIrq(mChg, mRx, mTx, ctl)});
    end

    // R2 latency: data set ready (index 1, live bit 4, flag bit 16)
    ctrlWord = '0;
    modemIn = 4'b0010;
    @(negedge clk);
    check("R2 live after one edge", statusWord & 32'h0001_0010, 32'h0);
    @(negedge clk);
    check("R2 live after two edges", statusWord & 32'h0001_0010, 32'h0000_0010);
    @(negedge clk);
    check("R3 flag after three edges", statusWord & 32'h0001_0010, 32'h0001_0010);

    // R7: second edge of clear to send coincides with clearing write
    modemIn = 4'b0110;
    repeat (3) @(negedge clk);
    check("R3 cts rise flag", statusWord & 32'h0002_0000, 32'h0002_0000);
    modemIn = 4'b0010;
    @(negedge clk);
    @(negedge clk);
    wrEn = 1'b1; wrData = 32'h0002_0000;
    @(negedge clk);
    wrEn = 1'b0; wrData = '0;
    check("R7 cts edge beats clear", statusWord & 32'h0002_0000, 32'h0002_0000);
    wrEn = 1'b1; wrData = 32'h0002_0000;
    @(negedge clk);
    wrEn = 1'b0; wrData = '0;
    check("R6 cts clear without edge", statusWord & 32'h0002_0000, 32'h0);

    rxEvent = 1'b1;
    @(negedge clk);
    rxEvent = 1'b1; wrEn = 1'b1; wrData = 32'h0000_0001;
    @(negedge clk);
    rxEvent = 1'b0; wrEn = 1'b0; wrData = '0;
    check("R7 rx event beats clear", statusWord & 32'h1, 32'h1);

    // R10: write back the whole word
    txEmptyEvent = 1'b1;
    @(negedge clk);
    txEmptyEvent = 1'b0;
    rd = statusWord;
    check("R10 word before write-back", rd, 32'h0201_0011);
    wrEn = 1'b1; wrData = rd;
    @(negedge clk);
    wrEn = 1'b0; wrData = '0;
    check("R10 word after write-back", statusWord, 32'h0000_0010);

    // R9: lines high through reset
    rstN = 1'b0;
    modemIn = 4'b1111;
    ctrlWord = 32'h0008_0005;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    repeat (6) @(negedge clk);
    check("R9 no flag from static high", statusWord, 32'h0000_0078);
    check("R9 irq quiet", {31'b0, irqReq}, 32'h0);

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end

endmodule